// File: doc/BRIEF.md
# Ones-complement add/subtract unit

A combinational arithmetic unit for ones-complement operands of a configurable width (8 bits by default). It adds or subtracts two operands, or negates the first. A select input routes the operation through one of two datapaths:

- An adder core, which feeds its carry back into the low end.
- A subtracter core, which feeds its borrow back into the low end.

Both cores give the same numeric result. They differ only in which of the two zero encodings they produce. This lets a designer compare how often all-ones negative zero appears.

Alongside the result the unit reports an overflow flag, a negative-zero flag and a zero flag. The zero flag accepts either zero encoding. Overflow comes from operand and result sign bits only, beside the arithmetic path.

Top module: `oc_arith_unit`

## Requirements
- R1: Opcode encoding is 2'b00 add (A+B), 2'b01 subtract (A-B), and 2'b10 or 2'b11 negate A. A negative value -v is encoded as the bitwise inverse of v, so -1 is 8'hFE at W=8. When no overflow occurs, the result's value is the exact integer sum or difference.
- R2: With core_sel_i=0 (adder core, end-around carry), a zero-valued add or subtract result is all ones, unless both effective addends are all zeros. The effective addends are A and B for add, and A and ~B for subtract.
- R3: With core_sel_i=1 (subtracter core, end-around borrow), a zero-valued result is all zeros, unless both effective addends are all ones. For add this means A=B=all ones; for subtract it means A all ones and B all zeros.
- R4: Negate gives the bitwise inverse of A, never flags overflow, and ignores B and core_sel_i.
- R5: ovf_o is high exactly when the true integer result of an add or subtract lies outside ±(2^(W-1)-1). Equivalently, both effective addends share a sign and the result's sign differs.
- R6: On overflow, the result encodes the true sum minus (2^W-1) for a positive sum, or plus (2^W-1) for a negative sum.
- R7: negz_o is high exactly when the result is all ones.
- R8: zero_o is high exactly when the result is all zeros or all ones.
- R9: For the same operands and opcode, both cores give the same overflow flag and the same numeric result. Only the zero encoding may differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, ones-complement |
| b_i | input | W | Second operand, ones-complement |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 1x negate A |
| core_sel_i | input | 1 | 0 selects the end-around-carry adder core, 1 the end-around-borrow subtracter core |
| res_o | output | W | Result, ones-complement |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| negz_o | output | 1 | Result is negative zero (all ones) |
| zero_o | output | 1 | Result is either zero encoding |

## Verification
Directed cases pit x against -x, which tells the cores apart by the zero encoding each emits. They also cover negative zero plus negative zero and positive zero plus positive zero, the only pairs that flip each core's default zero. Operands at the range limits of ±127 separate in-range sums from wrapped overflowed ones. Negation of both zeros and of the extremes, under both core selects, shows that the select and B play no part there. Random operands applied under both selects compare each core against an integer model, and tally the cases where the cores differ only in zero encoding.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_NEG     = 2'b10,
        OP_NEG_ALT = 2'b11
    } oc_op_e;

    // core selection values
    localparam logic CORE_CARRY  = 1'b0;
    localparam logic CORE_BORROW = 1'b1;

endpackage

// File: rtl/oc_eac_adder.sv
// Ones-complement adder: carry out of the top bit re-enters at bit 0.
module oc_eac_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] raw_d;

    always_comb begin
        raw_d = {1'b0, x_i} + {1'b0, y_i};
        // a single wrap suffices: raw low bits never exceed 2^W-2 when carry is set
        sum_o = raw_d[W-1:0] + W'(raw_d[W]);
    end
endmodule

// File: rtl/oc_eab_subber.sv
// Ones-complement subtracter: borrow out of the top bit is taken from bit 0.
module oc_eab_subber #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] diff_o
);
    logic [W:0] raw_d;

    always_comb begin
        raw_d  = {1'b0, x_i} - {1'b0, y_i};
        // when a borrow occurs the low bits are at least 1, so no second wrap
        diff_o = raw_d[W-1:0] - W'(raw_d[W]);
    end
endmodule

// File: rtl/oc_flag_gen.sv
// Status flags; overflow uses only sign bits so it sits beside the carry chain.
module oc_flag_gen #(
    parameter int W = 8
) (
    input  logic         p_sign_i,
    input  logic         q_sign_i,
    input  logic         is_neg_i,
    input  logic [W-1:0] res_i,
    output logic         ovf_o,
    output logic         negz_o,
    output logic         zero_o
);
    logic all_one_d;
    logic all_zero_d;

    always_comb begin
        all_one_d  = &res_i;
        all_zero_d = ~|res_i;
        ovf_o      = !is_neg_i && (p_sign_i == q_sign_i) && (res_i[W-1] != p_sign_i);
        negz_o     = all_one_d;
        zero_o     = all_one_d | all_zero_d;
    end
endmodule

// File: rtl/oc_arith_unit.sv
module oc_arith_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    input  logic         core_sel_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o,
    output logic         negz_o,
    output logic         zero_o
);
    import oc_pkg::*;

    oc_op_e       op_e;
    logic         is_neg_d;
    logic [W-1:0] q_d;        // effective second addend
    logic [W-1:0] sub_y_d;    // subtrahend fed to the borrow core
    logic [W-1:0] carry_res_d;
    logic [W-1:0] borrow_res_d;
    logic [W-1:0] res_d;

    always_comb begin
        op_e     = oc_op_e'(op_i);
        is_neg_d = (op_e == OP_NEG) || (op_e == OP_NEG_ALT);
        q_d      = (op_e == OP_SUB) ? ~b_i : b_i;
        // A + q == A - ~q, so the borrow core always subtracts ~q
        sub_y_d  = ~q_d;
    end

    oc_eac_adder #(.W(W)) u_carry (
        .x_i   (a_i),
        .y_i   (q_d),
        .sum_o (carry_res_d)
    );

    oc_eab_subber #(.W(W)) u_borrow (
        .x_i    (a_i),
        .y_i    (sub_y_d),
        .diff_o (borrow_res_d)
    );

    always_comb begin
        if (is_neg_d)
            res_d = ~a_i;
        else if (core_sel_i == CORE_BORROW)
            res_d = borrow_res_d;
        else
            res_d = carry_res_d;
    end

    oc_flag_gen #(.W(W)) u_flags (
        .p_sign_i (a_i[W-1]),
        .q_sign_i (q_d[W-1]),
        .is_neg_i (is_neg_d),
        .res_i    (res_d),
        .ovf_o    (ovf_o),
        .negz_o   (negz_o),
        .zero_o   (zero_o)
    );

    assign res_o = res_d;
endmodule

// File: rtl/oc_arith_chk.sv
module oc_arith_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [1:0]   op_i,
    input logic         core_sel_i,
    input logic [W-1:0] res_o,
    input logic         ovf_o,
    input logic         negz_o,
    input logic         zero_o
);
    logic [W-1:0] q_c;

    always_comb begin
        q_c = (op_i == 2'b01) ? ~b_i : b_i;

        // R4: negation inverts A and never overflows
        a_r4_neg_inverts : assert (!op_i[1] || (res_o == ~a_i && !ovf_o));

        // R2: adder core yields +0 only from two +0 addends
        a_r2_carry_poszero : assert (op_i[1] || core_sel_i || res_o != '0
                                     || (a_i == '0 && q_c == '0));

        // R3: subtracter core yields -0 only from two -0 addends
        a_r3_borrow_negzero : assert (op_i[1] || !core_sel_i || res_o != '1
                                      || (a_i == '1 && q_c == '1));

        // R5: overflow needs equal addend signs and a flipped result sign
        a_r5_ovf_signs : assert (!ovf_o || (a_i[W-1] == q_c[W-1] && res_o[W-1] != a_i[W-1]));

        // R8: negative zero is a zero
        a_r8_negz_is_zero : assert (!negz_o || zero_o);
    end
endmodule

bind oc_arith_unit oc_arith_chk #(.W(W)) u_chk (.*);

// File: tb/sim_oc_arith_unit.sv
module sim_oc_arith_unit;
    localparam int W    = 8;
    localparam int MAXV = 2 ** (W - 1) - 1;
    localparam int MODV = 2 ** W - 1;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, res;
    logic [1:0]   op;
    logic         sel, ovf, negz, zero;
    int           checks = 0;
    int           errors = 0;
    int           diffs  = 0;

    always #2 clk = ~clk;   // 250 MHz

    oc_arith_unit #(.W(W)) u0 (
        .a_i(a), .b_i(b), .op_i(op), .core_sel_i(sel),
        .res_o(res), .ovf_o(ovf), .negz_o(negz), .zero_o(zero)
    );

    function automatic int ocv(input logic [W-1:0] x);
        logic [W-1:0] t;
        t = ~x;
        return x[W-1] ? -int'(t) : int'(x);
    endfunction

    function automatic logic [W-1:0] enc(input int v);
        return (v >= 0) ? W'(v) : ~W'(-v);
    endfunction

    // reference from the requirements
    function automatic logic [W:0] model(input logic [W-1:0] ta, input logic [W-1:0] tb,
                                         input logic [1:0] top, input logic ts);
        logic [W-1:0] q, r;
        logic         ov;
        int           s;
        if (top[1]) return {1'b0, ~ta};
        q  = (top == 2'b01) ? ~tb : tb;
        s  = ocv(ta) + ocv(q);
        ov = (s > MAXV) || (s < -MAXV);
        if (ov) s = (s > 0) ? s - MODV : s + MODV;
        if (s != 0) r = enc(s);
        else if (!ts) r = (ta == '0 && q == '0) ? '0 : '1;
        else          r = (ta == '1 && q == '1) ? '1 : '0;
        return {ov, r};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
                         input logic [1:0] top, input logic ts);
        @(negedge clk);
        {a, b, op, sel} = {ta, tb, top, ts};
        #1;
    endtask

    task automatic run(input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic [1:0] top, input logic ts, input string rtag);
        logic [W:0] e;
        apply(ta, tb, top, ts);
        e = model(ta, tb, top, ts);
        chk(rtag, res, e[W-1:0]);
        chk("R5 ovf", W'(ovf), W'(e[W]));
        chk("R7 negz", W'(negz), W'(&e[W-1:0]));
        chk("R8 zero", W'(zero), W'((&e[W-1:0]) | ~|e[W-1:0]));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] r0;
        logic [W-1:0] r1;
        logic         o0;
        logic         o1;
        void'($urandom(32'd4242));
        // quiescent: all-zero inputs
        apply('0, '0, 2'b00, 1'b0);
        chk("R1 idle result", res, 8'h00);
        chk("R8 idle zero", W'(zero), 8'd1);
        // R1 basic values and -1 encoding
        run(8'h05, 8'h03, 2'b00, 1'b0, "R1 5+3");
        chk("R1 5+3 literal", res, 8'h08);
        run(8'h00, 8'h01, 2'b01, 1'b1, "R1 0-1");
        chk("R1 minus one encoding", res, 8'hFE);
        // R2 / R3: -1 + 1 on each core
        run(8'hFE, 8'h01, 2'b00, 1'b0, "R2 -1+1");
        chk("R2 adder gives -0", res, 8'hFF);
        run(8'hFE, 8'h01, 2'b00, 1'b1, "R3 -1+1");
        chk("R3 subtracter gives +0", res, 8'h00);
        run(8'hFF, 8'hFF, 2'b00, 1'b1, "R3 -0+-0");
        chk("R3 -0 from -0,-0", res, 8'hFF);
        run(8'hFF, 8'h00, 2'b01, 1'b1, "R3 -0 - +0");
        run(8'h00, 8'h00, 2'b00, 1'b0, "R2 +0++0");
        chk("R2 +0 from +0,+0", res, 8'h00);
        run(8'h2A, 8'h2A, 2'b01, 1'b0, "R2 x-x");
        run(8'h2A, 8'h2A, 2'b01, 1'b1, "R3 x-x");
        // R4 negation, core select ignored
        run(8'h00, 8'h5A, 2'b10, 1'b0, "R4 neg +0");
        chk("R4 neg +0 literal", res, 8'hFF);
        run(8'hFF, 8'hA5, 2'b11, 1'b1, "R4 neg -0");
        run(8'h7F, 8'h7F, 2'b10, 1'b1, "R4 neg max");
        chk("R4 neg no ovf", W'(ovf), 8'd0);
        // R5 / R6 overflow at the range limits
        run(8'h64, 8'h64, 2'b00, 1'b0, "R6 100+100");
        chk("R6 wrap literal", res, 8'hC8);
        run(8'h7F, 8'hFE, 2'b01, 1'b1, "R6 127-(-1)");
        run(8'h80, 8'h80, 2'b00, 1'b0, "R6 -127+-127");
        run(8'h7F, 8'h00, 2'b00, 1'b1, "R5 127+0 in range");
        // random vectors under both cores
        for (int i = 0; i < 1500; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic [1:0]   rop;
            ra  = W'($urandom);
            rb  = W'($urandom);
            rop = 2'($urandom);
            run(ra, rb, rop, 1'b0, "R1 random adder");
            r0 = res; o0 = ovf;
            run(ra, rb, rop, 1'b1, "R1 random subtracter");
            r1 = res; o1 = ovf;
            chk("R9 same ovf", W'(o1), W'(o0));
            chk("R9 same value", enc(ocv(r1)), enc(ocv(r0)));
            if (r0 != r1) diffs++;
        end
        $display("zero-encoding differences between cores: %0d", diffs);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule